// File: doc/BRIEF.md
# Bus turnaround idle-cycle inserter

This block sits beside the access sequencer of an external memory bus controller. It decides how many dead cycles must separate one external bus cycle from the next, so that a slow device still driving the data lines after a read does not collide with the following access. It remembers the chip-select area and direction of the last completed bus cycle. When a new cycle is wanted, it classifies the pair as write-then-any, read-then-write or read-then-read, each to the same or to another area. It then picks that transition's programmed idle count from the previous area's settings.

Cycles that pass naturally after an access count toward the requirement, so a long quiet gap adds no delay. The block gates the start of each 4-byte bus cycle with `start_ok`. 8-byte and 16-byte transfers are split into 2 or 4 such cycles, with turnaround enforced between the pieces. Before an external master is granted the bus, the same turnaround must have elapsed. CPU-initiated and DMA-initiated accesses are not told apart, so both get exactly the same spacing.

Top module: `bus_turnaround_gate`

## Requirements
- R1: Out of reset `start_ok`, `req_ready` and `bus_grant` are low and no previous access is recorded, so the first request is accepted (`req_ready` high) in the very cycle it is presented.
- R2: Each programmable area owns a 15-bit slot in `cfg_idle`; bits [2:0] of the slot give the idle code applied when the previous cycle in that area was a write, whatever follows.
- R3: After a read, slot bits [5:3] apply to a following write to another area and bits [8:6] to a following write to the same area.
- R4: After a read, slot bits [11:9] apply to a following read from another area and bits [14:12] to a following read from the same area.
- R5: An idle code c maps to 0, 1, 2, 4, 6, 8, 10, 12 cycles for c = 0..7; the count is the number of cycles strictly between the `acc_done` cycle and the `start_ok` cycle. Slots are ordered areas 0, 1, 2, 4, 5, 6 from bit 0 upward.
- R6: Areas 3 and 7 have no slot; a previous access to them yields zero idle cycles unless R8 applies.
- R7: Cycles elapsed since `acc_done` while waiting with no request count toward the requirement; a request presented g cycles later waits max(N − g, 0) idle cycles.
- R8: When the previous cycle was a read and the next request has `req_mux` set, at least one idle cycle is inserted even if the programmed count is zero; after a write this minimum does not apply.
- R9: With `ext_breq` high and no transfer in progress, `bus_grant` rises one cycle after the turnaround for the previous access has elapsed (write: bits [2:0]; read: largest of the four read fields). It stays high while `ext_breq` is high, no cycle starts while it is high, and after its release the previous-access record is cleared.
- R10: `req_size` codes 3 and 4 (8 and 16 bytes) are carried out as 2 and 4 bus cycles, each marked by a `start_ok` pulse, with the same-area rule of the request's direction enforced between them; other codes give one cycle.
- R11: After a cycle starts, `start_ok` stays low until `acc_done` has ended it.
- R12: A new request is not accepted while `ext_breq` is high; `req_ready` only rises together with `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_idle | input | 90 | Idle codes, six 15-bit area slots |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted; its first bus cycle starts this cycle |
| req_area | input | 3 | Chip-select area of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | 0:1, 1:2, 2:4, 3:8, 4:16 bytes |
| req_mux | input | 1 | Target area uses a multiplexed address/data bus |
| start_ok | output | 1 | One-cycle pulse: a 4-byte bus cycle starts |
| acc_done | input | 1 | Current bus cycle completes this cycle |
| ext_breq | input | 1 | External master requests the bus |
| bus_grant | output | 1 | Bus released to the external master |

## Verification
The hardest state to reach is a pause between pieces of a split burst. Here the remaining beats reuse the latched area and direction rather than the request ports, and the idle gap has to be timed against an `acc_done` that the bench itself produces. Directed tasks issue 8- and 16-byte transfers, answer every `start_ok` with a completion, and time each following gap. Grant timing is reached by raising `ext_breq` right after a write completes, with a request held pending so that blocking during the grant can be observed.

// File: rtl/bus_turnaround_gate.sv
module bus_turnaround_gate #(
  parameter int ELAPSED_W = 4,
  localparam int NSLOT = 6,
  localparam int SLOT_W = 15,
  localparam int CFG_W = NSLOT * SLOT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_idle,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_area,
  input  logic             req_write,
  input  logic [2:0]       req_size,
  input  logic             req_mux,
  output logic             start_ok,
  input  logic             acc_done,
  input  logic             ext_breq,
  output logic             bus_grant
);

  localparam logic [ELAPSED_W-1:0] ELAPSED_MAX = '1;

  function automatic logic [3:0] dec_code(input logic [2:0] c);
    case (c)
      3'd0: dec_code = 4'd0;
      3'd1: dec_code = 4'd1;
      3'd2: dec_code = 4'd2;
      3'd3: dec_code = 4'd4;
      3'd4: dec_code = 4'd6;
      3'd5: dec_code = 4'd8;
      3'd6: dec_code = 4'd10;
      default: dec_code = 4'd12;
    endcase
  endfunction

  logic                 prev_vld, prev_wr;
  logic [2:0]           prev_area;
  logic                 active;
  logic [2:0]           cur_area;
  logic                 cur_wr, cur_mux;
  logic [1:0]           beats_left;
  logic [ELAPSED_W-1:0] elapsed;
  logic                 bgnt;

  logic                 has_cfg;
  logic [2:0]           prev_slot;
  logic [SLOT_W-1:0]    flds;

  assign has_cfg   = (prev_area != 3'd3) && (prev_area != 3'd7);
  assign prev_slot = (prev_area < 3'd3) ? prev_area : prev_area - 3'd1;

  always_comb begin
    flds = '0;
    for (int s = 0; s < NSLOT; s++)
      if (has_cfg && prev_slot == 3'(s)) flds = cfg_idle[s*SLOT_W +: SLOT_W];
  end

  logic [3:0] d_wany, d_rwd, d_rws, d_rrd, d_rrs;
  assign d_wany = dec_code(flds[2:0]);
  assign d_rwd  = dec_code(flds[5:3]);
  assign d_rws  = dec_code(flds[8:6]);
  assign d_rrd  = dec_code(flds[11:9]);
  assign d_rrs  = dec_code(flds[14:12]);

  logic       idle_bus, pend_burst;
  logic [2:0] nx_area;
  logic       nx_wr, nx_mux, same_area;
  logic [3:0] base_need, need, rd_max_w, rd_max_r, rel_need;

  assign pend_burst = !active && (beats_left != 2'd0);
  assign idle_bus   = !active && (beats_left == 2'd0);
  assign nx_area    = pend_burst ? cur_area : req_area;
  assign nx_wr      = pend_burst ? cur_wr   : req_write;
  assign nx_mux     = pend_burst ? cur_mux  : req_mux;
  assign same_area  = (nx_area == prev_area);

  always_comb begin
    if (!prev_vld)    base_need = 4'd0;
    else if (prev_wr) base_need = d_wany;
    else if (nx_wr)   base_need = same_area ? d_rws : d_rwd;
    else              base_need = same_area ? d_rrs : d_rrd;
  end

  assign need = (prev_vld && !prev_wr && nx_mux && base_need == 4'd0) ? 4'd1 : base_need;

  assign rd_max_w = (d_rwd > d_rws) ? d_rwd : d_rws;
  assign rd_max_r = (d_rrd > d_rrs) ? d_rrd : d_rrs;
  assign rel_need = !prev_vld ? 4'd0 :
                    prev_wr   ? d_wany :
                    (rd_max_w > rd_max_r) ? rd_max_w : rd_max_r;

  logic want_start, grant_ok;
  assign want_start = pend_burst || (idle_bus && req_valid && !ext_breq);
  assign start_ok   = !active && !bgnt && want_start && (elapsed >= ELAPSED_W'(need));
  assign req_ready  = start_ok && !pend_burst;
  assign grant_ok   = idle_bus && !bgnt && ext_breq && (elapsed >= ELAPSED_W'(rel_need));
  assign bus_grant  = bgnt;

  logic [1:0] req_extra;
  assign req_extra = (req_size == 3'd4) ? 2'd3 : (req_size == 3'd3) ? 2'd1 : 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_vld   <= 1'b0;
      prev_wr    <= 1'b0;
      prev_area  <= '0;
      active     <= 1'b0;
      cur_area   <= '0;
      cur_wr     <= 1'b0;
      cur_mux    <= 1'b0;
      beats_left <= '0;
      elapsed    <= '0;
      bgnt       <= 1'b0;
    end else begin
      if (start_ok) begin
        active <= 1'b1;
        if (pend_burst) begin
          beats_left <= beats_left - 2'd1;
        end else begin
          cur_area   <= req_area;
          cur_wr     <= req_write;
          cur_mux    <= req_mux;
          beats_left <= req_extra;
        end
      end
      if (active && acc_done) begin
        active    <= 1'b0;
        prev_vld  <= 1'b1;
        prev_area <= cur_area;
        prev_wr   <= cur_wr;
        elapsed   <= '0;
      end else if (!active && elapsed != ELAPSED_MAX) begin
        elapsed <= elapsed + 1'b1;
      end
      if (grant_ok) begin
        bgnt <= 1'b1;
      end else if (bgnt && !ext_breq) begin
        bgnt     <= 1'b0;
        prev_vld <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bus_turnaround_gate_checker.sv
module bus_turnaround_gate_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic start_ok,
  input logic ext_breq,
  input logic bus_grant,
  input logic prev_vld,
  input logic idle_bus
);

  assert_first_access_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_vld && idle_bus && req_valid && !ext_breq && !bus_grant) |-> req_ready);

  assert_no_start_in_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ok && bus_grant));

  assert_grant_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && ext_breq) |=> bus_grant);

  assert_single_flight_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> !start_ok);

  assert_ready_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (req_valid && !ext_breq && start_ok));

endmodule

bind bus_turnaround_gate bus_turnaround_gate_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .start_ok(start_ok), .ext_breq(ext_breq), .bus_grant(bus_grant),
  .prev_vld(prev_vld), .idle_bus(idle_bus)
);

// File: tb/bus_turnaround_gate_bench.sv
`timescale 1ns/1ps
module bus_turnaround_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [89:0] cfg = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_mux = 1'b0;
  logic [2:0]  req_area = '0, req_size = 3'd2;
  logic        acc_done = 1'b0, ext_breq = 1'b0;
  logic        req_ready, start_ok, bus_grant;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  bus_turnaround_gate u_bus_turnaround_gate (
    .clk(clk), .rst_n(rst_n), .cfg_idle(cfg), .req_valid(req_valid), .req_ready(req_ready),
    .req_area(req_area), .req_write(req_write), .req_size(req_size), .req_mux(req_mux),
    .start_ok(start_ok), .acc_done(acc_done), .ext_breq(ext_breq), .bus_grant(bus_grant)
  );

  function automatic int dec(int c);
    case (c)
      0: return 0; 1: return 1; 2: return 2; 3: return 4;
      4: return 6; 5: return 8; 6: return 10; default: return 12;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // field: 0 write-any, 1 rd->wr other, 2 rd->wr same, 3 rd->rd other, 4 rd->rd same
  task automatic set_code(int area, int field, int code);
    int slot = (area < 3) ? area : area - 1;
    cfg[slot*15 + field*3 +: 3] = 3'(code);
  endtask

  task automatic set_all(int code);
    for (int a = 0; a < 7; a++)
      if (a != 3) for (int f = 0; f < 5; f++) set_code(a, f, code);
  endtask

  // Entry/exit: just after the negedge following the previous completion.
  task automatic issue(string tag, int area, bit wr, int size, bit mux, int gap, int hold,
                       int exp_first, int exp_beat);
    int cnt;
    int beats = (size == 4) ? 4 : (size == 3) ? 2 : 1;
    repeat (gap) @(negedge clk);
    req_area = 3'(area); req_write = wr; req_size = 3'(size); req_mux = mux; req_valid = 1'b1;
    #1; cnt = 0;
    while (!req_ready) begin @(negedge clk); #1; cnt++; end
    chk(tag, cnt, exp_first);
    @(negedge clk); req_valid = 1'b0;
    for (int h = 0; h < hold; h++) begin
      #1; chk("R11 no restart while busy", int'(start_ok), 0);
      @(negedge clk);
    end
    acc_done = 1'b1;
    for (int b = 1; b < beats; b++) begin
      @(negedge clk); acc_done = 1'b0;
      #1; cnt = 0;
      while (!start_ok) begin @(negedge clk); #1; cnt++; end
      chk("R10 idle between beats", cnt, exp_beat);
      @(negedge clk); acc_done = 1'b1;
    end
    @(negedge clk); acc_done = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk("R1 reset start_ok", int'(start_ok), 0);
    chk("R1 reset req_ready", int'(req_ready), 0);
    chk("R1 reset bus_grant", int'(bus_grant), 0);
    issue("R1 first access", 0, 1'b0, 2, 1'b0, 0, 0, 0, 0);
  endtask

  task automatic t_write_any;
    set_code(1, 0, 5); set_code(1, 1, 1); set_code(1, 3, 2);
    issue("R2 setup", 1, 1'b1, 2, 1'b0, 0, 0, 0, 0);
    issue("R2 write then read", 2, 1'b0, 2, 1'b0, 0, 0, dec(5), 0);
  endtask

  task automatic t_read_write;
    set_code(2, 1, 2); set_code(2, 2, 6);
    issue("R3 read then write other", 0, 1'b1, 2, 1'b0, 0, 0, dec(2), 0);
    issue("R3 setup", 2, 1'b0, 2, 1'b0, 0, 0, 0, 0);
    issue("R3 read then write same", 2, 1'b1, 2, 1'b0, 0, 0, dec(6), 0);
  endtask

  task automatic t_read_read;
    set_code(4, 3, 1); set_code(4, 4, 7);
    issue("R4 setup", 4, 1'b0, 2, 1'b0, 0, 0, 0, 0);
    issue("R4 read then read other", 5, 1'b0, 2, 1'b0, 0, 0, dec(1), 0);
    issue("R4 setup", 4, 1'b0, 2, 1'b0, 0, 0, 0, 0);
    issue("R4 read then read same", 4, 1'b0, 2, 1'b0, 0, 0, dec(7), 0);
  endtask

  task automatic t_codes;
    for (int c = 0; c < 8; c++) begin
      set_code(6, 0, c);
      issue("R5 setup", 6, 1'b1, 2, 1'b0, 0, 0, 0, 0);
      issue("R5 code decode", 0, 1'b0, 2, 1'b0, 0, 0, dec(c), 0);
    end
  endtask

  task automatic t_no_slot;
    set_all(7);
    issue("R6 into area 3", 3, 1'b0, 2, 1'b0, 0, 0, 12, 0);
    issue("R6 after area 3 read", 3, 1'b0, 2, 1'b0, 0, 0, 0, 0);
    issue("R6 area 7 write", 7, 1'b1, 2, 1'b0, 0, 0, 0, 0);
    issue("R6 after area 7 write", 0, 1'b0, 2, 1'b0, 0, 0, 0, 0);
  endtask

  task automatic t_gap;
    issue("R7 gap 3", 0, 1'b0, 2, 1'b0, 3, 0, 9, 0);
    issue("R7 gap 20", 0, 1'b0, 2, 1'b0, 20, 0, 0, 0);
    issue("R7 gap 12", 0, 1'b0, 2, 1'b0, 12, 0, 0, 0);
    issue("R7 gap 11", 0, 1'b0, 2, 1'b0, 11, 0, 1, 0);
  endtask

  task automatic t_mux;
    set_all(0);
    issue("R8 mux read after read", 1, 1'b0, 2, 1'b1, 0, 0, 1, 0);
    issue("R8 mux write after read", 1, 1'b1, 2, 1'b1, 0, 0, 1, 0);
    issue("R8 mux after write", 2, 1'b0, 2, 1'b1, 0, 0, 0, 0);
    issue("R8 mux gap absorbs", 2, 1'b0, 2, 1'b1, 1, 0, 0, 0);
  endtask

  task automatic t_burst;
    set_code(4, 4, 2); set_code(5, 0, 4);
    issue("R10 16-byte read", 4, 1'b0, 4, 1'b0, 15, 0, 0, dec(2));
    issue("R10 8-byte write", 5, 1'b1, 3, 1'b0, 15, 3, 0, dec(4));
    issue("R10 single after burst", 5, 1'b0, 1, 1'b0, 0, 0, dec(4), 0);
  endtask

  task automatic t_grant;
    int cnt;
    set_code(1, 0, 3); set_code(1, 3, 5); set_code(1, 4, 5);
    issue("R9 setup", 1, 1'b1, 2, 1'b0, 15, 0, 0, 0);
    ext_breq = 1'b1; req_area = 3'd1; req_write = 1'b0; req_size = 3'd2; req_mux = 1'b0;
    req_valid = 1'b1;
    #1; cnt = 0;
    while (!bus_grant) begin
      if (req_ready) chk("R12 request held off by bus request", 1, 0);
      @(negedge clk); #1; cnt++;
    end
    chk("R9 grant after release turnaround", cnt, dec(3) + 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R9 grant held", int'(bus_grant), 1);
      chk("R9 no start during grant", int'(start_ok), 0);
    end
    ext_breq = 1'b0; req_valid = 1'b0;
    @(negedge clk); #1;
    chk("R9 grant released", int'(bus_grant), 0);
    issue("R9 record cleared after release", 1, 1'b0, 2, 1'b0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_any();
    t_read_write();
    t_read_read();
    t_codes();
    t_no_slot();
    t_gap();
    t_mux();
    t_burst();
    t_grant();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule